// File: doc/BRIEF.md
# Parallel Crate Controller Command Decoder

This block sits between a parallel branch highway and a crate backplane (the dataway). A highway command carries a 7-bit crate field, a 5-bit station number, a 4-bit subaddress, a 5-bit function code and a 24-bit write word. When the controller's own crate bit is set in the crate field, the block expands the station number into a single station-select (N) line. It then runs one fixed dataway cycle: busy rises, a first strobe S1 samples the read data and the module responses, and a later strobe S2 marks the point where registers may change. The captured data word and the accept (X) and status (Q) responses go back to the highway.

Stations 24 and 25 are reserved for the controller itself. A station-select line exists only for stations 1 to 23. Commands to the reserved stations reach a small internal register set: a LAM enable mask, and a view of the masked LAM requests. Every module LAM is gated by its mask bit, and the gated LAMs are ORed into the single branch-demand output. The host can therefore test and mask each request source on its own.

Top module: `ccd_crate_ctrl`

## Requirements
- R1: A command whose crate field has bit CRATE_ID (default bit 0, the LSB) clear starts no dataway cycle. It completes with a one-cycle `hw_done` pulse in the cycle after acceptance, with `hw_x`=0, `hw_q`=0, `hw_rdata`=0 and `hw_drive`=0.
- R2: A command is acted on whenever its crate bit is set, whatever other crate bits are also set.
- R3: For station s in 1..23, `dw_n` is one-hot with bit s-1 set for every cycle that `dw_busy` is high. `dw_n` is zero whenever `dw_busy` is low.
- R4: Stations 0 and 24..31 raise no station-select line. Stations 0 and 26..31 return X=0, Q=0 and data 0.
- R5: `dw_busy` is high for exactly CYCLE_TICKS cycles. `dw_s1` is high for S1_LEN cycles starting at busy cycle S1_START. `dw_s2` is high for S2_LEN cycles starting at busy cycle S2_START. The two strobes never overlap, and neither is high outside busy.
- R6: `dw_a`, `dw_f` and `dw_w` carry the command's subaddress, function and write word, unchanged, for the whole busy period.
- R7: `dw_r`, `dw_x` and `dw_q` are captured during S1. After an addressed cycle, `hw_done` pulses in the cycle after busy falls and `hw_drive` goes to 1. The returned values hold until the next accepted command.
- R8: Station 24 or 25, subaddress 0, function 16 (write) loads the low 23 bits of the write word into the LAM mask during S2, and returns X=1, Q=1.
- R9: At station 24 or 25, subaddress 0 with function 0 (read) returns the mask, zero-extended. Subaddress 1 with function 0 returns the LAM lines ANDed with the mask. Both return X=1, Q=1. Any other subaddress or function there returns X=0, Q=0 and data 0, and leaves the mask unchanged.
- R10: `branch_demand` equals the OR of (`dw_lam` AND mask), one clock later.
- R11: While busy, `cmd_ready` is low. A command presented then is ignored: it changes neither the running cycle nor starts another one.
- R12: After reset the block is idle with `cmd_ready`=1, the mask is all zero, and `branch_demand`, `hw_x`, `hw_q`, `hw_drive` and `hw_done` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_valid | input | 1 | Highway command present |
| cmd_ready | output | 1 | Controller idle, command will be taken |
| cmd_crate | input | 7 | Crate select field, any subset of bits |
| cmd_station | input | 5 | Station number |
| cmd_sub | input | 4 | Subaddress |
| cmd_func | input | 5 | Function code |
| cmd_wdata | input | 24 | Write word |
| hw_rdata | output | 24 | Returned read word |
| hw_x | output | 1 | Returned accept response |
| hw_q | output | 1 | Returned status response |
| hw_drive | output | 1 | Crate drives the highway reply |
| hw_done | output | 1 | One-cycle completion pulse |
| branch_demand | output | 1 | OR of the enabled LAM requests |
| dw_busy | output | 1 | Dataway operation in progress |
| dw_s1 | output | 1 | First strobe, data transfer |
| dw_s2 | output | 1 | Second strobe, data change |
| dw_n | output | 23 | One station-select line per module station |
| dw_a | output | 4 | Dataway subaddress |
| dw_f | output | 5 | Dataway function code |
| dw_w | output | 24 | Dataway write lines |
| dw_r | input | 24 | Dataway read lines (wired OR) |
| dw_x | input | 1 | Module accept response |
| dw_q | input | 1 | Module status response |
| dw_lam | input | 23 | One LAM request per module station |

## Verification
The assertions check on every cycle that the strobes are mutually exclusive and confined to busy, and that no more than one station line is active and only while busy. They also check that the station and function lines stay frozen during a cycle, that results stay stable between commands, and that an unaddressed reply is silent. Only the bench scenarios can show the exact strobe positions and lengths, the decoding of each of the 32 station numbers and all 128 crate fields, the values returned by the modules and by the internal mask register, and the effect of a mask write on the branch demand. The bench sweeps all station numbers and crate fields, and checks every reserved-station register operation.

// File: rtl/ccd_pkg.sv
package ccd_pkg;

    localparam int CRATE_W = 7;
    localparam int STN_W   = 5;
    localparam int SUB_W   = 4;
    localparam int FN_W    = 5;
    localparam int DATA_W  = 24;

    // function codes honoured by the controller's own registers
    localparam logic [FN_W-1:0]  FN_RD = 5'd0;
    localparam logic [FN_W-1:0]  FN_WR = 5'd16;

    // subaddresses of the controller's own registers
    localparam logic [SUB_W-1:0] SUB_MASK = 4'd0;
    localparam logic [SUB_W-1:0] SUB_PEND = 4'd1;

    // stations held by the controller itself
    localparam logic [STN_W-1:0] STN_SELF_LO = 5'd24;
    localparam logic [STN_W-1:0] STN_SELF_HI = 5'd25;

    typedef struct packed {
        logic [STN_W-1:0]  stn;
        logic [SUB_W-1:0]  sub;
        logic [FN_W-1:0]   fn;
        logic [DATA_W-1:0] wdata;
    } cmd_t;

    function automatic logic is_self(input logic [STN_W-1:0] stn);
        return (stn == STN_SELF_LO) || (stn == STN_SELF_HI);
    endfunction

endpackage

// File: rtl/ccd_station_decode.sv
module ccd_station_decode
    import ccd_pkg::*;
#(
    parameter int NUM_SLOTS = 23
) (
    input  logic                 en,
    input  logic [STN_W-1:0]     stn,
    output logic [NUM_SLOTS-1:0] sel
);

    // station k drives select bit k-1; station 0 and stations above
    // NUM_SLOTS select nothing
    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
        assign sel[i] = en && (stn == STN_W'(i + 1));
    end

endmodule

// File: rtl/ccd_cycle_timer.sv
module ccd_cycle_timer #(
    parameter int CYCLE_TICKS = 250,
    parameter int S1_START    = 60,
    parameter int S1_LEN      = 40,
    parameter int S2_START    = 160,
    parameter int S2_LEN      = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic s1,
    output logic s2,
    output logic last
);

    localparam int CNT_W  = (CYCLE_TICKS > 2) ? $clog2(CYCLE_TICKS) : 1;
    localparam int S1_END = S1_START + S1_LEN;
    localparam int S2_END = S2_START + S2_LEN;

    typedef struct packed {
        logic             act;
        logic [CNT_W-1:0] cnt;
        logic             s1;
        logic             s2;
    } tmr_t;

    tmr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        last = st_q.act && (int'(st_q.cnt) == CYCLE_TICKS - 1);
        if (st_q.act) begin
            if (last) begin
                st_d.act = 1'b0;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end else if (start) begin
            st_d.act = 1'b1;
            st_d.cnt = '0;
        end
        st_d.s1 = st_d.act && (int'(st_d.cnt) >= S1_START) && (int'(st_d.cnt) < S1_END);
        st_d.s2 = st_d.act && (int'(st_d.cnt) >= S2_START) && (int'(st_d.cnt) < S2_END);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy = st_q.act;
    assign s1   = st_q.s1;
    assign s2   = st_q.s2;

endmodule

// File: rtl/ccd_lam_gate.sv
module ccd_lam_gate #(
    parameter int NUM_SLOTS = 23
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [NUM_SLOTS-1:0] wr_mask,
    input  logic [NUM_SLOTS-1:0] lam,
    output logic [NUM_SLOTS-1:0] mask,
    output logic [NUM_SLOTS-1:0] pending,
    output logic                 demand
);

    typedef struct packed {
        logic [NUM_SLOTS-1:0] mask;
        logic                 demand;
    } gate_t;

    gate_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        pending     = lam & st_q.mask;
        st_d.demand = |pending;
        if (wr_en) st_d.mask = wr_mask;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mask   = st_q.mask;
    assign demand = st_q.demand;

endmodule

// File: rtl/ccd_crate_ctrl.sv
module ccd_crate_ctrl
    import ccd_pkg::*;
#(
    parameter int CRATE_ID    = 0,
    parameter int NUM_SLOTS   = 23,
    parameter int CYCLE_TICKS = 250,
    parameter int S1_START    = 60,
    parameter int S1_LEN      = 40,
    parameter int S2_START    = 160,
    parameter int S2_LEN      = 40
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_valid,
    output logic                 cmd_ready,
    input  logic [CRATE_W-1:0]   cmd_crate,
    input  logic [STN_W-1:0]     cmd_station,
    input  logic [SUB_W-1:0]     cmd_sub,
    input  logic [FN_W-1:0]      cmd_func,
    input  logic [DATA_W-1:0]    cmd_wdata,
    output logic [DATA_W-1:0]    hw_rdata,
    output logic                 hw_x,
    output logic                 hw_q,
    output logic                 hw_drive,
    output logic                 hw_done,
    output logic                 branch_demand,
    output logic                 dw_busy,
    output logic                 dw_s1,
    output logic                 dw_s2,
    output logic [NUM_SLOTS-1:0] dw_n,
    output logic [SUB_W-1:0]     dw_a,
    output logic [FN_W-1:0]      dw_f,
    output logic [DATA_W-1:0]    dw_w,
    input  logic [DATA_W-1:0]    dw_r,
    input  logic                 dw_x,
    input  logic                 dw_q,
    input  logic [NUM_SLOTS-1:0] dw_lam
);

    typedef struct packed {
        cmd_t                 cmd;
        logic                 own;
        logic [NUM_SLOTS-1:0] n;
        logic [DATA_W-1:0]    rdata;
        logic                 x;
        logic                 q;
        logic                 drive;
        logic                 done;
    } ctl_t;

    ctl_t st_d, st_q;

    logic                 tm_start, tm_busy, tm_s1, tm_s2, tm_last;
    logic                 hit, accept, mask_we;
    logic [NUM_SLOTS-1:0] dec_sel, lam_mask, lam_pend;

    assign hit    = cmd_crate[CRATE_ID];
    assign accept = cmd_valid && !tm_busy;

    ccd_station_decode #(.NUM_SLOTS(NUM_SLOTS)) dec_i (
        .en  (hit),
        .stn (cmd_station),
        .sel (dec_sel)
    );

    ccd_cycle_timer #(
        .CYCLE_TICKS (CYCLE_TICKS),
        .S1_START    (S1_START),
        .S1_LEN      (S1_LEN),
        .S2_START    (S2_START),
        .S2_LEN      (S2_LEN)
    ) tmr_i (
        .clk   (clk),
        .rst_n (rst_n),
        .start (tm_start),
        .busy  (tm_busy),
        .s1    (tm_s1),
        .s2    (tm_s2),
        .last  (tm_last)
    );

    ccd_lam_gate #(.NUM_SLOTS(NUM_SLOTS)) lam_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (mask_we),
        .wr_mask (st_q.cmd.wdata[NUM_SLOTS-1:0]),
        .lam     (dw_lam),
        .mask    (lam_mask),
        .pending (lam_pend),
        .demand  (branch_demand)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        tm_start  = accept && hit;
        mask_we   = 1'b0;

        if (accept) begin
            st_d.rdata = '0;
            st_d.x     = 1'b0;
            st_d.q     = 1'b0;
            st_d.drive = 1'b0;
            if (hit) begin
                st_d.cmd.stn   = cmd_station;
                st_d.cmd.sub   = cmd_sub;
                st_d.cmd.fn    = cmd_func;
                st_d.cmd.wdata = cmd_wdata;
                st_d.own       = is_self(cmd_station);
                st_d.n         = dec_sel;
            end else begin
                st_d.done = 1'b1;
            end
        end

        // data capture window
        if (tm_s1) begin
            if (st_q.own) begin
                st_d.rdata = '0;
                st_d.x     = 1'b0;
                st_d.q     = 1'b0;
                if (st_q.cmd.sub == SUB_MASK && st_q.cmd.fn == FN_RD) begin
                    st_d.rdata = DATA_W'(lam_mask);
                    st_d.x     = 1'b1;
                    st_d.q     = 1'b1;
                end else if (st_q.cmd.sub == SUB_PEND && st_q.cmd.fn == FN_RD) begin
                    st_d.rdata = DATA_W'(lam_pend);
                    st_d.x     = 1'b1;
                    st_d.q     = 1'b1;
                end else if (st_q.cmd.sub == SUB_MASK && st_q.cmd.fn == FN_WR) begin
                    st_d.x     = 1'b1;
                    st_d.q     = 1'b1;
                end
            end else begin
                st_d.rdata = dw_r;
                st_d.x     = dw_x;
                st_d.q     = dw_q;
            end
        end

        // register-change window
        if (tm_s2 && st_q.own && st_q.cmd.sub == SUB_MASK && st_q.cmd.fn == FN_WR)
            mask_we = 1'b1;

        if (tm_last) begin
            st_d.n     = '0;
            st_d.done  = 1'b1;
            st_d.drive = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cmd_ready = !tm_busy;
    assign hw_rdata  = st_q.rdata;
    assign hw_x      = st_q.x;
    assign hw_q      = st_q.q;
    assign hw_drive  = st_q.drive;
    assign hw_done   = st_q.done;
    assign dw_busy   = tm_busy;
    assign dw_s1     = tm_s1;
    assign dw_s2     = tm_s2;
    assign dw_n      = st_q.n;
    assign dw_a      = st_q.cmd.sub;
    assign dw_f      = st_q.cmd.fn;
    assign dw_w      = st_q.cmd.wdata;

endmodule

// File: rtl/ccd_crate_ctrl_chk.sv
module ccd_crate_ctrl_chk
    import ccd_pkg::*;
#(
    parameter int NUM_SLOTS = 23
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cmd_valid,
    input logic                 cmd_ready,
    input logic [DATA_W-1:0]    hw_rdata,
    input logic                 hw_x,
    input logic                 hw_q,
    input logic                 hw_drive,
    input logic                 hw_done,
    input logic                 branch_demand,
    input logic                 dw_busy,
    input logic                 dw_s1,
    input logic                 dw_s2,
    input logic [NUM_SLOTS-1:0] dw_n,
    input logic [SUB_W-1:0]     dw_a,
    input logic [FN_W-1:0]      dw_f,
    input logic [DATA_W-1:0]    dw_w,
    input logic [NUM_SLOTS-1:0] dw_lam
);

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(dw_s1 && dw_s2)); // R5

    AST_STROBE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (dw_s1 || dw_s2) |-> dw_busy); // R5

    AST_N_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dw_n)); // R3

    AST_N_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !dw_busy |-> (dw_n == '0)); // R3

    AST_CMD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (dw_busy && $past(dw_busy)) |->
            ($stable(dw_n) && $stable(dw_a) && $stable(dw_f) && $stable(dw_w))); // R6

    AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dw_busy) |-> hw_done); // R7

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(dw_busy) && !$past(cmd_valid && cmd_ready)) |->
            ($stable(hw_rdata) && $stable(hw_x) && $stable(hw_q))); // R7

    AST_NACK_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_done && !hw_drive) |-> (!hw_x && !hw_q)); // R1

    AST_NO_LAM_NO_DEMAND: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(dw_lam) == '0) |-> !branch_demand); // R10

endmodule

bind ccd_crate_ctrl ccd_crate_ctrl_chk #(.NUM_SLOTS(NUM_SLOTS)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_valid     (cmd_valid),
    .cmd_ready     (cmd_ready),
    .hw_rdata      (hw_rdata),
    .hw_x          (hw_x),
    .hw_q          (hw_q),
    .hw_drive      (hw_drive),
    .hw_done       (hw_done),
    .branch_demand (branch_demand),
    .dw_busy       (dw_busy),
    .dw_s1         (dw_s1),
    .dw_s2         (dw_s2),
    .dw_n          (dw_n),
    .dw_a          (dw_a),
    .dw_f          (dw_f),
    .dw_w          (dw_w),
    .dw_lam        (dw_lam)
);

// File: tb/ccd_crate_ctrl_tb_top.sv
module ccd_crate_ctrl_tb_top;
    import ccd_pkg::*;

    localparam int SLOTS = 23;
    localparam int CYC   = 250;
    localparam int S1S   = 60;
    localparam int S1L   = 40;
    localparam int S2S   = 160;
    localparam int S2L   = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0;
    logic cmd_ready;
    logic [CRATE_W-1:0] cmd_crate = '0;
    logic [STN_W-1:0] cmd_station = '0;
    logic [SUB_W-1:0] cmd_sub = '0;
    logic [FN_W-1:0] cmd_func = '0;
    logic [DATA_W-1:0] cmd_wdata = '0;
    logic [DATA_W-1:0] hw_rdata;
    logic hw_x, hw_q, hw_drive, hw_done, branch_demand;
    logic dw_busy, dw_s1, dw_s2;
    logic [SLOTS-1:0] dw_n;
    logic [SUB_W-1:0] dw_a;
    logic [FN_W-1:0] dw_f;
    logic [DATA_W-1:0] dw_w;
    logic [DATA_W-1:0] dw_r;
    logic dw_x, dw_q;
    logic [SLOTS-1:0] dw_lam = '1;

    int checks = 0;
    int errors = 0;
    logic [SLOTS-1:0] mmod = '0;

    always #2 clk = ~clk;

    ccd_crate_ctrl #(
        .CRATE_ID(0), .NUM_SLOTS(SLOTS), .CYCLE_TICKS(CYC),
        .S1_START(S1S), .S1_LEN(S1L), .S2_START(S2S), .S2_LEN(S2L)
    ) dut_i (.*);

    function automatic logic [DATA_W-1:0] mod_word(input int s, input logic [SUB_W-1:0] a);
        return DATA_W'(s * 66051) ^ DATA_W'({a, 4'h0});
    endfunction

    // module population on the dataway
    always_comb begin
        dw_r = '0;
        dw_x = 1'b0;
        dw_q = 1'b0;
        for (int i = 0; i < SLOTS; i++) begin
            if (dw_n[i]) begin
                dw_r = dw_r | mod_word(i + 1, dw_a);
                dw_x = dw_x | (i + 1 != 7);
                dw_q = dw_q | (dw_a < 4'd8);
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [CRATE_W-1:0] c, input int s, input logic [SUB_W-1:0] a,
                         input logic [FN_W-1:0] f, input logic [DATA_W-1:0] w,
                         input bit hit, input logic [DATA_W-1:0] er, input bit ex, input bit eq,
                         input bit intrude, input string req);
        logic [SLOTS-1:0] en;
        int bc = 0, s1c = 0, s1f = -1, s2c = 0, s2f = -1, t = 0;
        bit ovl = 0, nbad = 0, afw = 0;
        en = (s >= 1 && s <= SLOTS) ? (SLOTS'(1) << (s - 1)) : '0;
        @(negedge clk);
        cmd_crate = c; cmd_station = STN_W'(s); cmd_sub = a; cmd_func = f; cmd_wdata = w;
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        while (!hw_done && t < 2000) begin
            if (dw_busy) begin
                if (dw_s1) begin if (s1f < 0) s1f = bc; s1c++; end
                if (dw_s2) begin if (s2f < 0) s2f = bc; s2c++; end
                if (dw_s1 && dw_s2) ovl = 1;
                if (dw_n !== en) nbad = 1;
                if (dw_a !== a || dw_f !== f || dw_w !== w) afw = 1;
                bc++;
            end else if (dw_s1 || dw_s2) ovl = 1;
            if (intrude) begin
                cmd_valid = (bc == 10);
                cmd_station = 5'd9;
            end
            @(negedge clk);
            t++;
        end
        cmd_valid = 1'b0;
        chk(hw_done === 1'b1, "R7 done pulse", 32'(hw_done), 1);
        if (hit) begin
            chk(bc == CYC, "R5 busy length", bc, CYC);
            chk(s1f == S1S && s1c == S1L, "R5 S1 window", {s1f[15:0], s1c[15:0]}, {16'(S1S), 16'(S1L)});
            chk(s2f == S2S && s2c == S2L, "R5 S2 window", {s2f[15:0], s2c[15:0]}, {16'(S2S), 16'(S2L)});
            chk(!ovl, "R5 strobe overlap", ovl, 0);
            chk(!nbad, (en == '0) ? "R4 no select line" : "R3 select line", nbad, 0);
            chk(!afw, "R6 A/F/W lines", afw, 0);
            chk(hw_drive === 1'b1, "R7 drive after cycle", 32'(hw_drive), 1);
        end else begin
            chk(bc == 0, "R1 no cycle when unaddressed", bc, 0);
            chk(hw_drive === 1'b0, "R1 bus undriven", 32'(hw_drive), 0);
        end
        chk(hw_rdata === er, {req, " data"}, 32'(hw_rdata), 32'(er));
        chk(hw_x === ex && hw_q === eq, {req, " X/Q"}, {hw_x, hw_q}, {ex, eq});
        if (intrude) begin
            repeat (3) @(negedge clk);
            chk(!dw_busy, "R11 ignored while busy", 32'(dw_busy), 0);
        end
    endtask

    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog R5 actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [DATA_W-1:0] held;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state, all LAMs requesting but mask cleared
        chk(cmd_ready && !dw_busy && dw_n == '0, "R12 idle after reset", {cmd_ready, dw_busy}, 2'b10);
        chk(!hw_x && !hw_q && !hw_drive && !hw_done, "R12 reply cleared", {hw_x, hw_q, hw_drive, hw_done}, 0);
        chk(!branch_demand, "R12 demand masked", 32'(branch_demand), 0);
        issue(7'h01, 24, SUB_MASK, FN_RD, '0, 1, '0, 1, 1, 0, "R12 mask reset");

        // R1 R2: every crate field, station 3 sub 2 read
        for (int c = 0; c < 128; c++) begin
            if (c[0]) issue(7'(c), 3, 4'd2, FN_RD, 24'h0, 1, mod_word(3, 4'd2), 1, 1, 0, "R2 crate field");
            else      issue(7'(c), 3, 4'd2, FN_RD, 24'h0, 0, '0, 0, 0, 0, "R1 crate field");
        end

        // R3 R4 R6 R7: every station number with varied sub/func/write word
        for (int s = 0; s < 32; s++) begin
            logic [SUB_W-1:0] a;
            logic [DATA_W-1:0] w;
            a = 4'(s * 5);
            w = DATA_W'(s * 24'h0B1357) ^ 24'h5A0000;
            if (s >= 1 && s <= SLOTS)
                issue(7'h41, s, a, 5'(s + 1), w, 1, mod_word(s, a), (s != 7), (a < 4'd8), 0, "R7 module read");
            else
                issue(7'h41, s, a, 5'(s + 1), w, 1, '0, 0, 0, 0, "R4 empty or reserved station");
        end

        // R7 hold after completion
        held = hw_rdata;
        repeat (10) @(negedge clk);
        chk(hw_rdata === held && hw_drive, "R7 reply held", 32'(hw_rdata), 32'(held));

        // R11 command during busy is ignored
        issue(7'h01, 5, 4'd1, 5'd2, 24'h123456, 1, mod_word(5, 4'd1), 1, 1, 1, "R11 running cycle");

        // R8 R9 R10 mask and pending
        dw_lam = '0;
        issue(7'h01, 24, SUB_MASK, FN_WR, 24'hFFA5C3, 1, '0, 1, 1, 0, "R8 mask write");
        mmod = SLOTS'(24'hFFA5C3);
        issue(7'h01, 25, SUB_MASK, FN_RD, '0, 1, DATA_W'(mmod), 1, 1, 0, "R9 mask read");
        for (int b = 0; b < SLOTS; b += 4) begin
            @(negedge clk);
            dw_lam = SLOTS'(1) << b;
            @(negedge clk);
            @(negedge clk);
            chk(branch_demand === |(dw_lam & mmod), "R10 demand", 32'(branch_demand), 32'(|(dw_lam & mmod)));
        end
        dw_lam = SLOTS'(23'h0F0F0F);
        issue(7'h01, 24, SUB_PEND, FN_RD, '0, 1, DATA_W'(dw_lam & mmod), 1, 1, 0, "R9 pending read");
        issue(7'h01, 25, SUB_MASK, 5'd17, 24'h000001, 1, '0, 0, 0, 0, "R9 bad own function");
        issue(7'h01, 24, 4'd2, FN_RD, '0, 1, '0, 0, 0, 0, "R9 bad own subaddress");
        issue(7'h01, 24, SUB_MASK, FN_RD, '0, 1, DATA_W'(mmod), 1, 1, 0, "R9 mask unchanged");
        issue(7'h01, 25, SUB_MASK, FN_WR, 24'h000000, 1, '0, 1, 1, 0, "R8 mask clear");
        mmod = '0;
        @(negedge clk);
        @(negedge clk);
        chk(!branch_demand, "R10 demand after clear", 32'(branch_demand), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule